// File: doc/BRIEF.md
# Condition Flag Register with Branch Predicate Unit

This block sits beside an integer ALU. Whenever the ALU asserts its flag-write strobe, the block captures five one-bit condition flags from the operation: sign, zero, carry, overflow and parity. The flags are taken from the 32-bit result, the carry-out and the overflow indication. A compare is simply an ALU subtraction whose result nobody writes back. Its only lasting effect is the new flag state, so the block treats it like any other flag-writing operation.

The flags stay as they are until the next strobe. A conditional branch can therefore test the outcome of whatever operation last wrote them, with no compare of its own. The branch side is purely combinational. A 4-bit condition code selects a predicate over the stored flags, and the taken/not-taken answer comes back in the same cycle.

Top module: `cond_flag_unit`

## Requirements
- R1: Synchronous active-high reset clears all five flags to 0. After reset, condition 0 (equal) is not taken, condition 1 (not equal) is taken, condition 6 (below) is not taken, condition 7 (above or equal) is taken, condition 10 (parity even) is not taken and condition 14 is taken.
- R2: When flag_we is high at a rising edge, the sign flag becomes bit 31 of alu_res. Condition 12 (negative) is taken when the sign flag is 1, and condition 13 (positive) is taken when it is 0.
- R3: When flag_we is high at a rising edge, the zero flag becomes 1 exactly when all 32 bits of alu_res are 0. Condition 0 (equal) is taken when the zero flag is 1, and condition 1 (not equal) is taken when it is 0.
- R4: When flag_we is high at a rising edge, the carry flag becomes alu_carry, read as a borrow for subtract-based compares. The unsigned conditions are: 6 below = C, 7 above-or-equal = !C, 8 below-or-equal = C|Z, 9 above = !C&!Z.
- R5: When flag_we is high at a rising edge, the parity flag becomes 1 when alu_res[7:0] holds an even number of ones. Bits 31:8 have no effect on it. Condition 10 is taken on parity 1 and condition 11 on parity 0.
- R6: When flag_we is high at a rising edge, the overflow flag becomes alu_ovf. The signed conditions are: 2 less = S^O, 3 greater-or-equal = !(S^O), 4 less-or-equal = Z|(S^O), 5 greater = !Z&!(S^O).
- R7: When flag_we is low at a rising edge, all flags keep their values, whatever alu_res, alu_carry and alu_ovf carry.
- R8: br_taken is a combinational function of br_cond and the stored flags. In a cycle where flag_we is high, the answer still reflects the flags from before that edge. The new flags govern br_taken from the cycle after the edge.
- R9: Condition 14 is always taken and condition 15 is never taken, whatever the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flag_we | input | 1 | Flag-write strobe from the ALU |
| alu_res | input | 32 | ALU result |
| alu_carry | input | 1 | ALU carry-out (borrow on subtract) |
| alu_ovf | input | 1 | ALU signed overflow |
| br_cond | input | 4 | Branch condition code |
| br_taken | output | 1 | Branch predicate result |

## Verification
The flag write and the branch query can fall in the same cycle. A branch evaluated there must see the flags from before the write, not the ones being written. The bench sets a known flag state, then in one cycle raises flag_we with a result that flips the zero flag while querying equal. It checks br_taken once before the rising edge, expecting the old answer, and once after it, expecting the new one. The rest of the bench sweeps all sixteen codes after each of more than a hundred flag-writing operations and compares each answer with a predicate computed from the applied inputs.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic o;
        logic p;
    } flags_t;

    typedef enum logic [3:0] {
        CC_EQ   = 4'd0,
        CC_NE   = 4'd1,
        CC_LT   = 4'd2,
        CC_GE   = 4'd3,
        CC_LE   = 4'd4,
        CC_GT   = 4'd5,
        CC_B    = 4'd6,
        CC_AE   = 4'd7,
        CC_BE   = 4'd8,
        CC_A    = 4'd9,
        CC_PE   = 4'd10,
        CC_PO   = 4'd11,
        CC_NEG  = 4'd12,
        CC_POS  = 4'd13,
        CC_ALW  = 4'd14,
        CC_NEV  = 4'd15
    } cond_e;

    // even number of ones over a bit slice
    function automatic logic even_ones(input logic [7:0] v, input int unsigned w);
        logic acc;
        acc = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (i < w) acc = acc ^ v[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/flag_capture.sv
module flag_capture
    import cond_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_we,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    output flags_t            flags_q
);
    localparam int MSB = DATA_W - 1;

    flags_t flags_d;
    logic [7:0] par_slice;

    always_comb begin
        par_slice = '0;
        par_slice[PAR_W-1:0] = alu_res[PAR_W-1:0];
    end

    always_comb begin
        flags_d.s = alu_res[MSB];
        flags_d.z = (alu_res == '0);
        flags_d.c = alu_carry;
        flags_d.o = alu_ovf;
        flags_d.p = even_ones(par_slice, PAR_W);
    end

    always_ff @(posedge clk) begin
        if (rst)          flags_q <= '0;
        else if (flag_we) flags_q <= flags_d;
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_q));

    // R2
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> flags_q.s == $past(alu_res[MSB]));

    // R4
    carry_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> flags_q.c == $past(alu_carry));

    // R5
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> flags_q.p == ~(^$past(alu_res[PAR_W-1:0])));

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import cond_flag_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] cond,
    output logic       taken
);
    logic signed_lt;
    logic unsigned_be;
    logic base;

    assign signed_lt   = flags.s ^ flags.o;
    assign unsigned_be = flags.c | flags.z;

    // even codes test a predicate, the odd code above negates it
    always_comb begin
        unique case (cond[3:1])
            3'd0: base = flags.z;
            3'd1: base = signed_lt;
            3'd2: base = flags.z | signed_lt;
            3'd3: base = flags.c;
            3'd4: base = unsigned_be;
            3'd5: base = flags.p;
            3'd6: base = flags.s;
            default: base = 1'b1;
        endcase
    end

    // pairs 4/5 and 8/9 are defined with the "strict" form on the odd code
    assign taken = cond[0] ? ~base : base;

endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cond_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_we,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic [3:0]        br_cond,
    output logic              br_taken
);
    flags_t flags_q;

    flag_capture #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .flag_we   (flag_we),
        .alu_res   (alu_res),
        .alu_carry (alu_carry),
        .alu_ovf   (alu_ovf),
        .flags_q   (flags_q)
    );

    branch_eval u_eval (
        .flags (flags_q),
        .cond  (br_cond),
        .taken (br_taken)
    );

    // R9
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (br_cond == CC_ALW) |-> br_taken);

    // R9
    never_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (br_cond == CC_NEV) |-> !br_taken);

    // R3
    zero_eq_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && alu_res == '0) |=> (br_cond != CC_EQ || br_taken));

endmodule

// File: tb/cond_flag_unit_test.sv
`timescale 1ns/100ps
module cond_flag_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        flag_we;
    logic [31:0] alu_res;
    logic        alu_carry;
    logic        alu_ovf;
    logic [3:0]  br_cond;
    logic        br_taken;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic es, ez, ec, eo, ep;

    cond_flag_unit uut (
        .clk(clk), .rst(rst), .flag_we(flag_we), .alu_res(alu_res),
        .alu_carry(alu_carry), .alu_ovf(alu_ovf), .br_cond(br_cond),
        .br_taken(br_taken)
    );

    always #10 clk = ~clk;

    function automatic logic model(input logic [3:0] c);
        logic lt;
        lt = es ^ eo;
        case (c)
            4'd0:  return ez;
            4'd1:  return !ez;
            4'd2:  return lt;
            4'd3:  return !lt;
            4'd4:  return ez | lt;
            4'd5:  return !ez & !lt;
            4'd6:  return ec;
            4'd7:  return !ec;
            4'd8:  return ec | ez;
            4'd9:  return !ec & !ez;
            4'd10: return ep;
            4'd11: return !ep;
            4'd12: return es;
            4'd13: return !es;
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] c);
        case (c)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3, 4'd4, 4'd5: return "R6";
            4'd6, 4'd7, 4'd8, 4'd9: return "R4";
            4'd10, 4'd11: return "R5";
            4'd12, 4'd13: return "R2";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cond=%0d actual=%0b expected=%0b", req, br_cond, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int c = 0; c < 16; c++) begin
            br_cond = 4'(c);
            #0.5;
            check(req.len() > 0 ? req : tag(4'(c)), br_taken, model(4'(c)));
        end
    endtask

    task automatic write_flags(input logic [31:0] r, input logic cy, input logic ov);
        @(negedge clk);
        flag_we = 1'b1; alu_res = r; alu_carry = cy; alu_ovf = ov;
        @(negedge clk);
        flag_we = 1'b0;
        es = r[31]; ez = (r == 32'd0); ec = cy; eo = ov; ep = ~(^r[7:0]);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flag_we = 1'b0; alu_res = '0; alu_carry = 1'b0;
        alu_ovf = 1'b0; br_cond = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        es = 0; ez = 0; ec = 0; eo = 0; ep = 0;
        // R1 reset state
        sweep("R1");

        // main sweep over results, carries and overflows
        for (int k = 0; k < 132; k++) begin
            logic [31:0] r;
            logic [7:0]  lo;
            lo = 8'(k * 37);
            if (k < 128) r = {k[6], {23{k[5]}}, lo};
            else         r = 32'd0;
            write_flags(r, k[0] ^ k[3], k[1] ^ k[4]);
            sweep("");
            if (k % 8 == 3) begin
                // R7 hold: strobe low, inputs change, flags must not
                @(negedge clk);
                alu_res = ~r; alu_carry = ~alu_carry; alu_ovf = ~alu_ovf;
                repeat (2) @(negedge clk);
                sweep("R7");
            end
        end

        // R5 upper bits ignored: same low byte, different upper bits
        write_flags(32'hFFFF_FF03, 1'b0, 1'b0);
        br_cond = 4'd10; #0.5; check("R5", br_taken, 1'b1);
        write_flags(32'h0000_0103, 1'b0, 1'b0);
        br_cond = 4'd10; #0.5; check("R5", br_taken, 1'b1);
        write_flags(32'h8000_0007, 1'b0, 1'b0);
        br_cond = 4'd11; #0.5; check("R5", br_taken, 1'b1);

        // R8 write and query in the same cycle
        write_flags(32'd0, 1'b0, 1'b0);
        @(negedge clk);
        flag_we = 1'b1; alu_res = 32'd1; br_cond = 4'd0;
        #2;
        check("R8", br_taken, 1'b1);
        @(posedge clk);
        #2;
        flag_we = 1'b0;
        check("R8", br_taken, 1'b0);

        // R1 reset in the middle of a run
        write_flags(32'hFFFF_FFFF, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        es = 0; ez = 0; ec = 0; eo = 0; ep = 0;
        sweep("R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule